// File: doc/BRIEF.md
# CPU clock rate-change sequencer

This block steps a CPU clock domain safely through a frequency change. A pre-change request arrives before the main PLL is reprogrammed. The sequencer then does four things in order. It looks up the divider settings for the requested rate. If needed, it slows the core divider to a safe ratio. It moves the domain onto the alternate clock source and confirms the switch through a status field. Finally it loads the divider words for the new rate.

A post-change request arrives once the PLL is stable. The block then moves the domain back to the main source and restores the core divider field.

All register traffic goes through a single-cycle read/write port to the clock-controller register block. The read data is combinational. Every status poll is bounded by a programmable cycle limit.

Slots on the register port:
- 0: source select
- 1: select status
- 2: divider word 0
- 3: divider word 1
- 4: divider-0 status
- 5: divider-1 status

The table gives each entry's rate in kHz. The request rates are given in Hz.

Top module: `cpu_clk_seq`

## Requirements
- R1: On a pre-change request, the entry used is the first one whose rate times 1000 equals the new rate. If an entry of rate 0 comes first, or no entry matches, err_o pulses for one cycle. In that case the block makes no register write and gives no done pulse.
- R2: A safe divider is applied only when the alternate rate is above the old rate or the old rate is above the new rate. Otherwise the first write of the pre phase goes to slot 0.
- R3: The safe ratio is ceil(alternate / min(old, new)) - 1. When that value is 8 or more, warn_o pulses and the ratio is clamped to 7.
- R4: The safe write is a read-modify-write of divider word 0. It changes only the core field [2:0] (plus [18:16] in debug mode). It is followed by a wait until the divider-0 status bits under that mask read 0.
- R5: After the safe step, bit 16 of slot 0 is set and the block waits for status field [18:16] of slot 1 to read 2.
- R6: Next, divider word 0 is written with the table word ORed with the safe word, and the block waits for all divider-0 status bits to read 0. When a second divider exists, divider word 1 is then written with its table word and the block waits the same way on slot 5.
- R7: A post-change request clears bit 16 of slot 0 and waits for the status field to read 1. It then writes 0 into core field [2:0] of divider word 0, keeping the other bits, and waits for those status bits to clear.
- R8: In debug mode, field [18:16] of divider word 0 is forced to 7 during the safe step. The post phase restores that field from the matching table entry. In this mode a post request with no matching entry pulses err_o and makes no write.
- R9: A status wait that is not satisfied within tout_cycles_i cycles sets tout_o, which stays set until reset. The sequence then continues with the next step.
- R10: Requests that arrive while busy_o is high are ignored. done_o pulses for exactly one cycle at the end of each phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_req_i | input | 1 | Pre-change request pulse |
| post_req_i | input | 1 | Post-change request pulse |
| old_rate_i | input | RW | Current main rate, Hz |
| new_rate_i | input | RW | Target main rate, Hz |
| alt_rate_i | input | RW | Alternate source rate, Hz |
| tbl_rate_i | input | N_ENT*RW | Entry rates in kHz, entry 0 in the low bits |
| tbl_div0_i | input | N_ENT*DW | Divider word 0 per entry |
| tbl_div1_i | input | N_ENT*DW | Divider word 1 per entry |
| tout_cycles_i | input | CW | Status wait limit in cycles |
| reg_addr_o | output | 4 | Register slot |
| reg_we_o | output | 1 | Write strobe |
| reg_wdata_o | output | DW | Write data |
| reg_rdata_i | input | DW | Read data of the addressed slot |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Phase complete pulse |
| err_o | output | 1 | No table match pulse |
| warn_o | output | 1 | Safe ratio clamped pulse |
| tout_o | output | 1 | Sticky status timeout |

## Verification
The assertions check several properties on every cycle:
- done is a single-cycle pulse.
- Writes occur only while busy.
- The error pulse never coincides with an active sequence.
- The timeout flag stays set once set.
- The safe read-modify-write keeps every bit outside the divider mask.
- The divider reload always follows a confirmed source switch.

The bench scenarios cover the rest:
- the order and values of the writes for raised, lowered and clamped rate changes;
- table misses, including a new rate of zero meeting the end marker;
- requests dropped while busy;
- timed-out waits that still run to completion;
- the debug-field force and restore.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  localparam int unsigned AW     = 4;
  localparam int unsigned FLD_W  = 3;
  localparam int unsigned MUX_POS = 16;
  localparam int unsigned DBG_POS = 16;

  localparam logic [AW-1:0] A_SEL      = 4'd0;
  localparam logic [AW-1:0] A_SEL_STAT = 4'd1;
  localparam logic [AW-1:0] A_DIV0     = 4'd2;
  localparam logic [AW-1:0] A_DIV1     = 4'd3;
  localparam logic [AW-1:0] A_D0_STAT  = 4'd4;
  localparam logic [AW-1:0] A_D1_STAT  = 4'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_SAFE_WR, S_SAFE_WT, S_MUX_WR, S_MUX_WT,
    S_D0_WR, S_D0_WT, S_D1_WR, S_D1_WT, S_DONE
  } seq_st_e;
endpackage

// File: rtl/clk_rate_lookup.sv
module clk_rate_lookup #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned RW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic [N_ENT*RW-1:0] tbl_rate_i,
  input  logic [N_ENT*DW-1:0] tbl_div0_i,
  input  logic [N_ENT*DW-1:0] tbl_div1_i,
  input  logic [RW-1:0]       new_rate_i,
  output logic                hit_o,
  output logic [DW-1:0]       div0_o,
  output logic [DW-1:0]       div1_o
);
  localparam int unsigned PW = RW + 10;

  logic [N_ENT-1:0] zero_v, match_v;
  logic [DW-1:0]    d0_a [N_ENT];
  logic [DW-1:0]    d1_a [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [RW-1:0] rate;
    assign rate       = tbl_rate_i[i*RW +: RW];
    assign zero_v[i]  = (rate == '0);
    assign match_v[i] = ({10'd0, rate} * PW'(1000)) == {10'd0, new_rate_i};
    assign d0_a[i]    = tbl_div0_i[i*DW +: DW];
    assign d1_a[i]    = tbl_div1_i[i*DW +: DW];
  end

  // first entry wins; a zero-rate entry ends the scan
  always_comb begin
    logic stop;
    stop   = 1'b0;
    hit_o  = 1'b0;
    div0_o = '0;
    div1_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!stop) begin
        if (zero_v[i]) begin
          stop = 1'b1;
        end else if (match_v[i]) begin
          stop   = 1'b1;
          hit_o  = 1'b1;
          div0_o = d0_a[i];
          div1_o = d1_a[i];
        end
      end
    end
  end
endmodule

// File: rtl/clk_safe_div.sv
module clk_safe_div #(
  parameter int unsigned RW = 32
) (
  input  logic [RW-1:0] alt_rate_i,
  input  logic [RW-1:0] old_rate_i,
  input  logic [RW-1:0] new_rate_i,
  output logic          need_o,
  output logic [2:0]    div_o,
  output logic          over_o
);
  localparam int unsigned PW = RW + 4;

  logic [RW-1:0] min_rate;
  logic [7:0]    fits;

  assign min_rate = (old_rate_i < new_rate_i) ? old_rate_i : new_rate_i;
  assign need_o   = (alt_rate_i > old_rate_i) || (old_rate_i > new_rate_i);

  // fits[k]: alt <= (k+1)*min, so ceil(alt/min) <= k+1
  for (genvar k = 0; k < 8; k++) begin : g_mul
    assign fits[k] = {4'd0, alt_rate_i} <= (PW'(k + 1) * {4'd0, min_rate});
  end

  always_comb begin
    div_o  = 3'd7;
    over_o = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      if (fits[k]) begin
        div_o  = 3'(k);
        over_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_wait_timer.sv
module clk_wait_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i)       cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = active_i && (cnt_q >= limit_i);

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq
  import clk_seq_pkg::*;
#(
  parameter int unsigned N_ENT    = 4,
  parameter int unsigned RW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned CW       = 16,
  parameter bit          HAS_DIV1 = 1'b1,
  parameter bit          DBG_DIV  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pre_req_i,
  input  logic                post_req_i,
  input  logic [RW-1:0]       old_rate_i,
  input  logic [RW-1:0]       new_rate_i,
  input  logic [RW-1:0]       alt_rate_i,
  input  logic [N_ENT*RW-1:0] tbl_rate_i,
  input  logic [N_ENT*DW-1:0] tbl_div0_i,
  input  logic [N_ENT*DW-1:0] tbl_div1_i,
  input  logic [CW-1:0]       tout_cycles_i,
  output logic [AW-1:0]       reg_addr_o,
  output logic                reg_we_o,
  output logic [DW-1:0]       reg_wdata_o,
  input  logic [DW-1:0]       reg_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic                warn_o,
  output logic                tout_o
);
  localparam logic [DW-1:0] CORE_MASK = DW'(7);
  localparam logic [DW-1:0] DBG_MASK  = DBG_DIV ? (DW'(7) << DBG_POS) : '0;
  localparam logic [DW-1:0] FLD_MASK  = CORE_MASK | DBG_MASK;
  localparam logic [DW-1:0] SEL_BIT   = DW'(1) << MUX_POS;

  seq_st_e       st_q, st_d;
  logic          post_q, err_q, warn_q, tout_q;
  logic [DW-1:0] d0_q, d1_q, fv_q;
  logic          hit, need, over, in_wait, ok, expired;
  logic [DW-1:0] div0_sel, div1_sel, safe_w;
  logic [2:0]    sdiv;

  clk_rate_lookup #(.N_ENT(N_ENT), .RW(RW), .DW(DW)) u_lookup (
    .tbl_rate_i(tbl_rate_i), .tbl_div0_i(tbl_div0_i), .tbl_div1_i(tbl_div1_i),
    .new_rate_i(new_rate_i), .hit_o(hit), .div0_o(div0_sel), .div1_o(div1_sel)
  );

  clk_safe_div #(.RW(RW)) u_safe (
    .alt_rate_i(alt_rate_i), .old_rate_i(old_rate_i), .new_rate_i(new_rate_i),
    .need_o(need), .div_o(sdiv), .over_o(over)
  );

  clk_wait_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(in_wait),
    .limit_i(tout_cycles_i), .expired_o(expired)
  );

  assign safe_w = DW'(sdiv) | DBG_MASK;

  always_comb begin
    st_d        = st_q;
    reg_addr_o  = A_SEL;
    reg_we_o    = 1'b0;
    reg_wdata_o = '0;
    in_wait     = 1'b0;
    ok          = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (pre_req_i) begin
          if (hit) st_d = need ? S_SAFE_WR : S_MUX_WR;
        end else if (post_req_i && (hit || !DBG_DIV)) begin
          st_d = S_MUX_WR;
        end
      end
      S_SAFE_WR: begin
        reg_addr_o  = A_DIV0;
        reg_we_o    = 1'b1;
        reg_wdata_o = (reg_rdata_i & ~FLD_MASK) | (fv_q & FLD_MASK);
        st_d        = S_SAFE_WT;
      end
      S_SAFE_WT: begin
        reg_addr_o = A_D0_STAT;
        in_wait    = 1'b1;
        ok         = (reg_rdata_i & FLD_MASK) == '0;
        if (ok || expired) st_d = post_q ? S_DONE : S_MUX_WR;
      end
      S_MUX_WR: begin
        reg_addr_o  = A_SEL;
        reg_we_o    = 1'b1;
        reg_wdata_o = post_q ? (reg_rdata_i & ~SEL_BIT) : (reg_rdata_i | SEL_BIT);
        st_d        = S_MUX_WT;
      end
      S_MUX_WT: begin
        reg_addr_o = A_SEL_STAT;
        in_wait    = 1'b1;
        ok         = reg_rdata_i[MUX_POS +: FLD_W] == (post_q ? 3'd1 : 3'd2);
        if (ok || expired) st_d = post_q ? S_SAFE_WR : S_D0_WR;
      end
      S_D0_WR: begin
        reg_addr_o  = A_DIV0;
        reg_we_o    = 1'b1;
        reg_wdata_o = d0_q;
        st_d        = S_D0_WT;
      end
      S_D0_WT: begin
        reg_addr_o = A_D0_STAT;
        in_wait    = 1'b1;
        ok         = reg_rdata_i == '0;
        if (ok || expired) st_d = HAS_DIV1 ? S_D1_WR : S_DONE;
      end
      S_D1_WR: begin
        reg_addr_o  = A_DIV1;
        reg_we_o    = 1'b1;
        reg_wdata_o = d1_q;
        st_d        = S_D1_WT;
      end
      S_D1_WT: begin
        reg_addr_o = A_D1_STAT;
        in_wait    = 1'b1;
        ok         = reg_rdata_i == '0;
        if (ok || expired) st_d = S_DONE;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      post_q <= 1'b0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      tout_q <= 1'b0;
      d0_q   <= '0;
      d1_q   <= '0;
      fv_q   <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (pre_req_i) begin
          if (!hit) begin
            err_q <= 1'b1;
          end else begin
            post_q <= 1'b0;
            fv_q   <= safe_w;
            d0_q   <= div0_sel | (need ? safe_w : '0);
            d1_q   <= div1_sel;
            warn_q <= need && over;
          end
        end else if (post_req_i) begin
          if (DBG_DIV && !hit) begin
            err_q <= 1'b1;
          end else begin
            post_q <= 1'b1;
            fv_q   <= div0_sel & DBG_MASK;
          end
        end
      end
      if (in_wait && expired && !ok) tout_q <= 1'b1;
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
  assign err_o  = err_q;
  assign warn_o = warn_q;
  assign tout_o = tout_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_WE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> busy_o); // R10
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R1
  AST_TOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |=> tout_o); // R9
  AST_SAFE_KEEPS_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SAFE_WR) |-> ((reg_wdata_o & ~FLD_MASK) == (reg_rdata_i & ~FLD_MASK))); // R4
  AST_RELOAD_AFTER_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_D0_WR) |-> ($past(st_q) == S_MUX_WT)); // R6
endmodule

// File: tb/tb_cpu_clk_seq.sv
module tb_regmodel #(
  parameter logic [31:0] INIT0 = 32'h0,
  parameter int          LAT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        hang,
  output logic [31:0] rdata
);
  logic [31:0] sel_q, div0_q, div1_q;
  int mux_cnt, d0_cnt, d1_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 0; div0_q <= INIT0; div1_q <= 0;
      mux_cnt <= 0; d0_cnt <= 0; d1_cnt <= 0;
    end else begin
      if (mux_cnt > 0) mux_cnt <= mux_cnt - 1;
      if (d0_cnt > 0) d0_cnt <= d0_cnt - 1;
      if (d1_cnt > 0) d1_cnt <= d1_cnt - 1;
      if (we) begin
        case (addr)
          4'd0: begin sel_q <= wdata; mux_cnt <= LAT; end
          4'd2: begin div0_q <= wdata; d0_cnt <= LAT; end
          4'd3: begin div1_q <= wdata; d1_cnt <= LAT; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0: rdata = sel_q;
      4'd1: rdata = (hang || mux_cnt != 0) ? 32'h0 : ((sel_q[16] ? 32'd2 : 32'd1) << 16);
      4'd2: rdata = div0_q;
      4'd3: rdata = div1_q;
      4'd4: rdata = (hang || d0_cnt != 0) ? 32'hFFFF_FFFF : 32'h0;
      4'd5: rdata = (hang || d1_cnt != 0) ? 32'hFFFF_FFFF : 32'h0;
      default: rdata = 32'h0;
    endcase
  end
endmodule

module tb_cpu_clk_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] old_r, new_r, alt_r;
  logic [127:0] t_rate, t_d0, t_d1;
  logic [15:0] tout_lim;
  logic pre0, post0, pre1, post1, hang0;

  logic [3:0]  a0, a1;
  logic        we0, we1, busy0, busy1, done0, done1, err0, err1, warn0, warn1, to0, to1;
  logic [31:0] wd0, wd1, rd0, rd1;

  cpu_clk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .pre_req_i(pre0), .post_req_i(post0),
    .old_rate_i(old_r), .new_rate_i(new_r), .alt_rate_i(alt_r),
    .tbl_rate_i(t_rate), .tbl_div0_i(t_d0), .tbl_div1_i(t_d1), .tout_cycles_i(tout_lim),
    .reg_addr_o(a0), .reg_we_o(we0), .reg_wdata_o(wd0), .reg_rdata_i(rd0),
    .busy_o(busy0), .done_o(done0), .err_o(err0), .warn_o(warn0), .tout_o(to0));

  cpu_clk_seq #(.DBG_DIV(1'b1)) dut_dbg (
    .clk_i(clk), .rst_ni(rst_n), .pre_req_i(pre1), .post_req_i(post1),
    .old_rate_i(old_r), .new_rate_i(new_r), .alt_rate_i(alt_r),
    .tbl_rate_i(t_rate), .tbl_div0_i(t_d0), .tbl_div1_i(t_d1), .tout_cycles_i(tout_lim),
    .reg_addr_o(a1), .reg_we_o(we1), .reg_wdata_o(wd1), .reg_rdata_i(rd1),
    .busy_o(busy1), .done_o(done1), .err_o(err1), .warn_o(warn1), .tout_o(to1));

  tb_regmodel #(.INIT0(32'h5)) m0 (.clk(clk), .rst_n(rst_n), .addr(a0), .we(we0),
    .wdata(wd0), .hang(hang0), .rdata(rd0));
  tb_regmodel #(.INIT0(32'h0)) m1 (.clk(clk), .rst_n(rst_n), .addr(a1), .we(we1),
    .wdata(wd1), .hang(1'b0), .rdata(rd1));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [3:0]  la0 [16];
  logic [31:0] ld0 [16];
  logic [31:0] ld1 [16];
  int n0 = 0, n1 = 0, dcnt0 = 0;
  bit warn_seen = 0;

  always @(negedge clk) begin
    if (we0 && n0 < 16) begin la0[n0] = a0; ld0[n0] = wd0; n0++; end
    if (we1 && n1 < 16) begin ld1[n1] = wd1; n1++; end
    if (warn0) warn_seen = 1;
    if (done0) dcnt0++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n0 = 0; n1 = 0; warn_seen = 0;
  endtask

  task automatic rates(input logic [31:0] o, input logic [31:0] n, input logic [31:0] a);
    old_r = o; new_r = n; alt_r = a;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: pre0 = 1; 1: post0 = 1; 2: pre1 = 1; default: post1 = 1; endcase
    @(negedge clk);
    pre0 = 0; post0 = 0; pre1 = 0; post1 = 0;
  endtask

  task automatic wait_end(input bit dbg, output bit d, output bit e);
    d = 0; e = 0;
    for (int i = 0; i < 400 && !d && !e; i++) begin
      if (dbg ? done1 : done0) d = 1;
      if (dbg ? err1 : err0) e = 1;
      if (!d && !e) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 32'(busy0), 0);
    chk("R10 reset done", 32'(done0), 0);
    chk("R1 reset err", 32'(err0), 0);
    chk("R9 reset tout", 32'(to0), 0);
    chk("R3 reset warn", 32'(warn0), 0);
  endtask

  task automatic t_up_no_safe();
    bit d, e;
    clr_log(); rates(800000, 1000000, 700000);
    pulse(0); wait_end(0, d, e);
    chk("R10 up done", 32'(d), 1);
    chk("R2 up write count", n0, 3);
    chk("R2 up first addr sel", 32'(la0[0]), 0);
    chk("R5 up sel value", ld0[0], 32'h0001_0000);
    chk("R6 up div0 word", ld0[1], 32'h0003_0450);
    chk("R6 up div1 word", ld0[2], 32'h21);
  endtask

  task automatic t_post_plain();
    bit d, e;
    clr_log();
    pulse(1); wait_end(0, d, e);
    chk("R7 post done", 32'(d), 1);
    chk("R7 post count", n0, 2);
    chk("R7 post first addr sel", 32'(la0[0]), 0);
    chk("R7 post sel cleared", m0.sel_q, 0);
    chk("R7 post div0", m0.div0_q, 32'h0003_0450);
  endtask

  task automatic t_down_safe();
    bit d, e;
    clr_log(); rates(1000000, 500000, 800000);
    pulse(0); wait_end(0, d, e);
    chk("R2 down count", n0, 4);
    chk("R4 down safe rmw addr", 32'(la0[0]), 2);
    chk("R3 R4 down safe value", ld0[0], 32'h0003_0451);
    chk("R5 down sel second", 32'(la0[1]), 0);
    chk("R6 down div0 or safe", ld0[2], 32'h0001_0231);
    chk("R6 down div1", m0.div1_q, 32'h11);
    chk("R3 down no warn", 32'(warn_seen), 0);
    clr_log(); pulse(1); wait_end(0, d, e);
    chk("R7 down restore core field", m0.div0_q, 32'h0001_0230);
  endtask

  task automatic t_warn_clamp();
    bit d, e;
    clr_log(); rates(500000, 800000, 5000000);
    pulse(0); wait_end(0, d, e);
    chk("R3 warn pulse", 32'(warn_seen), 1);
    chk("R3 clamped safe", ld0[0], 32'h0001_0237);
    chk("R6 clamped reload", ld0[2], 32'h0002_0347);
    pulse(1); wait_end(0, d, e);
  endtask

  task automatic t_miss();
    bit d, e;
    int dc;
    clr_log(); dc = dcnt0; rates(800000, 900000, 700000);
    pulse(0); wait_end(0, d, e);
    chk("R1 miss err", 32'(e), 1);
    chk("R1 miss no write", n0, 0);
    chk("R1 miss no done", dcnt0 - dc, 0);
    clr_log(); rates(800000, 0, 700000);
    pulse(0); wait_end(0, d, e);
    chk("R1 end marker err", 32'(e), 1);
    chk("R1 end marker no write", n0, 0);
  endtask

  task automatic t_busy_ignore();
    bit d, e;
    int dc;
    clr_log(); dc = dcnt0; rates(800000, 1000000, 700000);
    @(negedge clk); pre0 = 1;
    @(negedge clk); pre0 = 0; post0 = 1;
    @(negedge clk); post0 = 0;
    wait_end(0, d, e);
    repeat (20) @(negedge clk);
    chk("R10 busy single done", dcnt0 - dc, 1);
    chk("R10 busy post dropped", m0.sel_q, 32'h0001_0000);
    chk("R10 busy write count", n0, 3);
  endtask

  task automatic t_timeout();
    bit d, e;
    clr_log(); chk("R9 tout clear before", 32'(to0), 0);
    hang0 = 1; tout_lim = 16'd5;
    pulse(1); wait_end(0, d, e);
    hang0 = 0;
    chk("R9 timeout still done", 32'(d), 1);
    chk("R9 timeout flag", 32'(to0), 1);
    chk("R9 sequence continued", n0, 2);
    repeat (5) @(negedge clk);
    chk("R9 flag sticky", 32'(to0), 1);
  endtask

  task automatic t_debug();
    bit d, e;
    clr_log(); rates(1000000, 800000, 700000);
    pulse(2); wait_end(1, d, e);
    chk("R8 dbg safe forces field", ld1[0], 32'h0007_0000);
    chk("R8 dbg reload keeps forced", m1.div0_q, 32'h0007_0340);
    clr_log(); pulse(3); wait_end(1, d, e);
    chk("R8 dbg post restores field", m1.div0_q, 32'h0002_0340);
    clr_log(); rates(800000, 900000, 700000);
    pulse(3); wait_end(1, d, e);
    chk("R8 dbg post miss err", 32'(e), 1);
    chk("R8 dbg post miss no write", n1, 0);
  endtask

  initial begin
    pre0 = 0; post0 = 0; pre1 = 0; post1 = 0; hang0 = 0;
    tout_lim = 16'd1000;
    rates(0, 0, 0);
    t_rate = {32'd0, 32'd500, 32'd800, 32'd1000};
    t_d0   = {32'h0, 32'h0001_0230, 32'h0002_0340, 32'h0003_0450};
    t_d1   = {32'h0, 32'h11, 32'h12, 32'h21};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_up_no_safe();
    t_post_plain();
    t_down_safe();
    t_warn_clamp();
    t_miss();
    t_busy_ignore();
    t_timeout();
    t_debug();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule